// File: doc/BRIEF.md
# Three-State Phase Comparator with Polarity Select

This block sits between two programmable dividers and the charge pump of a frequency synthesizer. It watches the rising edges of the divided reference `ref_div` and the divided feedback `fb_div`. Both are sampled on a fast system clock. From them it produces one three-state correction output, which is modelled as a drive enable `drv_en` plus a drive level `drv_lvl`. When the reference edge arrives first the block asks for a correction in one direction. When the feedback edge arrives first it asks for the opposite one. When both edges arrive together the output floats.

The `polarity` input sets which level means "raise the VCO frequency". This lets one design serve oscillators whose frequency climbs with control voltage and oscillators whose frequency falls with it. Internally the comparator is a two-state-bit phase-frequency detector. Each input's edge arms its own state, and the state clears as soon as both have armed. Because of this, a frequency error keeps the drive on across several edges of the faster input.

A lock monitor counts consecutive reference edges seen while the output stayed floating. It raises `locked` once that count reaches a programmable threshold.

Top module: `phase_comparator_tri`

## Requirements
- R1: While reset is applied, and after its synchronous release until the first input edge, `drv_en`, `drv_lvl` and `locked` are all 0.
- R2: A `ref_div` rising edge without a `fb_div` rising edge in the same clock, with the comparator idle, starts driving at that clock edge: `drv_en`=1, and `drv_lvl`=1 when `polarity`=1 or `drv_lvl`=0 when `polarity`=0.
- R3: A `fb_div` rising edge without a `ref_div` rising edge in the same clock, with the comparator idle, starts driving at that clock edge: `drv_en`=1, and `drv_lvl`=0 when `polarity`=1 or `drv_lvl`=1 when `polarity`=0.
- R4: Once driving, the output stays driven across further rising edges of the same input. It returns to high impedance (`drv_en`=0) at the clock edge that samples a rising edge of the other input.
- R5: Rising edges of both inputs sampled in the same clock cause no drive at all.
- R6: `drv_lvl` follows a change of `polarity` in the same cycle while driving, and `drv_lvl` is 0 whenever `drv_en` is 0.
- R7: Each `ref_div` rising edge sampled while `drv_en`=0 increments a lock count. `locked` becomes 1 at the clock edge where the count reaches `lock_count`.
- R8: A clock edge at which `drv_en`=1 clears the lock count, and `locked` reads 0 after that edge.
- R9: `locked` requires a nonzero count, so with `lock_count`=0 it stays 0 until one clean reference edge has been counted.
- R10: The lock count saturates at its maximum (2^LOCK_W-1) instead of wrapping, so `locked` stays 1 at threshold 2^LOCK_W-1.
- R11: Only rising edges act. A falling edge, or an input held high, changes neither the drive nor the pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that samples both divided signals |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_div | input | 1 | Divided reference signal |
| fb_div | input | 1 | Divided feedback signal |
| polarity | input | 1 | 1: reference-leading drives high; 0: reference-leading drives low |
| lock_count | input | LOCK_W | Number of consecutive clean reference edges required for lock |
| drv_en | output | 1 | 1 drives the loop-filter node, 0 leaves it at high impedance |
| drv_lvl | output | 1 | Level driven while `drv_en` is 1 |
| locked | output | 1 | Lock-detect flag |

## Verification
The bench builds the block with `LOCK_W`=3. This keeps the lock count's ceiling at 7, so a run of nine coincident reference and feedback edges crosses it and shows saturation against wrap-around within a few dozen cycles. Thresholds of 3, 7 and 0 are applied at run time. Together they cover the ordinary lock point, the saturation point and the zero-threshold case with the same build.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [1:0] {
    PD_IDLE = 2'b00,
    PD_UP   = 2'b01,
    PD_DN   = 2'b10
  } pd_state_e;

  localparam int unsigned N_INPUTS = 2;
  localparam int unsigned IDX_REF  = 0;
  localparam int unsigned IDX_FB   = 1;

  function automatic logic drive_level(pd_state_e st, logic pol);
    logic lvl;
    case (st)
      PD_UP:   lvl = pol;
      PD_DN:   lvl = ~pol;
      default: lvl = 1'b0;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = sig;
    rise   = sig & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rise_ref,
  input  logic      rise_fb,
  output pd_state_e state
);

  pd_state_e state_q;
  pd_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PD_IDLE: begin
        if (rise_ref && !rise_fb)      state_d = PD_UP;
        else if (rise_fb && !rise_ref) state_d = PD_DN;
        else                           state_d = PD_IDLE;
      end
      PD_UP:   if (rise_fb)  state_d = PD_IDLE;
      PD_DN:   if (rise_ref) state_d = PD_IDLE;
      default: state_d = PD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PD_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  AST_UP_ON_REF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_IDLE && rise_ref && !rise_fb) |=> state_q == PD_UP); // R2
  AST_DN_ON_FB_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_IDLE && rise_fb && !rise_ref) |=> state_q == PD_DN); // R3
  AST_UP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_UP && rise_fb) |=> state_q == PD_IDLE); // R4
  AST_UP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_UP && !rise_fb) |=> state_q == PD_UP); // R4
  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_DN && !rise_ref) |=> state_q == PD_DN); // R4
  AST_COINCIDENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_IDLE && rise_ref && rise_fb) |=> state_q == PD_IDLE); // R5

endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
  parameter int unsigned LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_rise,
  input  logic              drive_active,
  input  logic [LOCK_W-1:0] lock_count,
  output logic              locked
);

  localparam logic [LOCK_W-1:0] CNT_MAX = {LOCK_W{1'b1}};

  logic [LOCK_W-1:0] cnt_q, cnt_d;
  logic              locked_q, locked_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = drive_active | ref_rise;
    cnt_d  = cnt_q;
    if (drive_active)              cnt_d = '0;
    else if (ref_rise && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    locked_d = (cnt_d != '0) && (cnt_d >= lock_count);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      locked_q <= locked_d;
    end
  end

  assign locked = locked_q;

  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    drive_active |=> !locked_q); // R8
  AST_COUNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !drive_active) |=> cnt_q == CNT_MAX); // R10
  AST_LOCK_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> cnt_q != '0); // R9

endmodule

// File: rtl/phase_comparator_tri.sv
module phase_comparator_tri
  import pfd_pkg::*;
#(
  parameter int unsigned LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_div,
  input  logic              fb_div,
  input  logic              polarity,
  input  logic [LOCK_W-1:0] lock_count,
  output logic              drv_en,
  output logic              drv_lvl,
  output logic              locked
);

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [N_INPUTS-1:0] in_vec;
  logic [N_INPUTS-1:0] rise_vec;

  assign in_vec[IDX_REF] = ref_div;
  assign in_vec[IDX_FB]  = fb_div;

  for (genvar gi = 0; gi < N_INPUTS; gi++) begin : g_edge
    pfd_edge_det i_edge (
      .clk  (clk),
      .rst_n(rst_sync_q),
      .sig  (in_vec[gi]),
      .rise (rise_vec[gi])
    );
  end

  pd_state_e pd_state;

  pfd_core i_core (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .rise_ref(rise_vec[IDX_REF]),
    .rise_fb (rise_vec[IDX_FB]),
    .state   (pd_state)
  );

  always_comb begin
    drv_en  = (pd_state != PD_IDLE);
    drv_lvl = drive_level(pd_state, polarity);
  end

  pfd_lock_mon #(.LOCK_W(LOCK_W)) i_lock (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .ref_rise    (rise_vec[IDX_REF]),
    .drive_active(drv_en),
    .lock_count  (lock_count),
    .locked      (locked)
  );

  AST_FLOAT_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !drv_en |-> !drv_lvl); // R6
  AST_HELD_HIGH_NO_ACTION: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!drv_en && $stable(ref_div) && $stable(fb_div)) |=> !drv_en); // R11

endmodule

// File: tb/test_phase_comparator_tri.sv
module test_phase_comparator_tri;

  localparam int unsigned LOCK_W = 3;
  localparam int          NVEC   = 22;

  logic              clk;
  logic              rst_n;
  logic              ref_div, fb_div, polarity;
  logic [LOCK_W-1:0] lock_count;
  logic              drv_en, drv_lvl, locked;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  phase_comparator_tri #(.LOCK_W(LOCK_W)) i_phase_comparator_tri (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_div   (ref_div),
    .fb_div    (fb_div),
    .polarity  (polarity),
    .lock_count(lock_count),
    .drv_en    (drv_en),
    .drv_lvl   (drv_lvl),
    .locked    (locked)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {ref, fb, pol, expected drv_en, expected drv_lvl}
  localparam logic [4:0] VEC [NVEC] = '{
    5'b00100, // idle
    5'b10111, // R2 ref edge, pol 1 -> high
    5'b10111, // R4 held high, still driving
    5'b11100, // R4 fb edge releases
    5'b00100, // R11 falling edges, nothing
    5'b01110, // R3 fb edge, pol 1 -> low
    5'b11100, // R4 ref edge releases
    5'b00100,
    5'b11100, // R5 coincident
    5'b00100,
    5'b10010, // R2 pol 0 -> low
    5'b11000, // R4 release
    5'b00000,
    5'b01011, // R3 pol 0 -> high
    5'b01110, // R6 polarity flip while driving
    5'b11100, // R4 release
    5'b00100,
    5'b10111, // R4 frequency: ref first edge
    5'b00111, // R11 ref falls, still driving
    5'b10111, // R4 second ref edge, still driving
    5'b11100, // R4 fb releases
    5'b00100
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic f, input logic p);
    @(negedge clk);
    ref_div  = r;
    fb_div   = f;
    polarity = p;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    ref_div = 1'b0;
    fb_div  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic coincident_pulse();
    step(1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    rst_n      = 1'b0;
    ref_div    = 1'b0;
    fb_div     = 1'b0;
    polarity   = 1'b1;
    lock_count = 3'd3;
    #12;
    check("R1 drv_en in reset", drv_en, 1'b0);
    check("R1 locked in reset", locked, 1'b0);
    do_reset();
    check("R1 drv_en after release", drv_en, 1'b0);
    check("R1 drv_lvl after release", drv_lvl, 1'b0);
    check("R1 locked after release", locked, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][4], VEC[i][3], VEC[i][2]);
      check($sformatf("R2/R3/R4/R5/R6/R11 vec %0d drv_en", i), drv_en, VEC[i][1]);
      check($sformatf("R6 vec %0d drv_lvl", i), drv_lvl, VEC[i][0]);
    end

    // R7: lock after three clean reference edges
    do_reset();
    lock_count = 3'd3;
    coincident_pulse();
    check("R7 locked after 1", locked, 1'b0);
    coincident_pulse();
    check("R7 locked after 2", locked, 1'b0);
    coincident_pulse();
    check("R7 locked after 3", locked, 1'b1);
    // R8: drive clears lock
    step(1'b1, 1'b0, 1'b1);
    check("R8 locked at ref-only edge", locked, 1'b1);
    check("R8 drive started", drv_en, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    check("R8 locked after drive cycle", locked, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1);

    // R10: saturation at 7
    lock_count = 3'd7;
    for (int k = 0; k < 7; k++) coincident_pulse();
    check("R10 locked at 7", locked, 1'b1);
    coincident_pulse();
    check("R10 locked after 8th edge", locked, 1'b1);
    coincident_pulse();
    check("R10 locked after 9th edge", locked, 1'b1);

    // R9: zero threshold needs a counted edge
    lock_count = 3'd0;
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    check("R9 locked cleared by drive", locked, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    check("R9 locked with zero count", locked, 1'b0);
    coincident_pulse();
    check("R9 locked after one clean edge", locked, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule